// File: doc/BRIEF.md
# Descriptor Table Register Load Sequencer

The block loads either the local descriptor table register or the task register from a 16-bit selector. On `start` it captures the selector, the load kind and the global table base. It screens the request against the current mode, the privilege level and the selector itself. If the request passes, it fetches the 8-byte descriptor as two 32-bit words through a request/acknowledge memory port. It then checks the descriptor's type and presence. When every check passes, the selector and the raw descriptor are latched into the chosen register and its valid bit is set. A task register load also writes the descriptor's high word back with the busy bit set, and only then latches.

The first check that fails ends the sequence. It reports a fault kind and a 16-bit error code, and the stored register state is left untouched. Every sequence ends with a one-cycle `done` pulse. `fault_kind` and `err_code` hold their values until the next start. The fault kinds are encoded as 0 none, 1 undefined opcode, 2 general protection and 3 not present.

Top module: `dtr_load_seq`

## Requirements
- R1: With `prot_mode` low (real or virtual-8086 mode) a start ends with fault kind 1 and error code 0, and no memory access takes place.
- R2: In protected mode, a `cpl` other than 0 ends with fault kind 2 and error code 0. No memory is accessed.
- R3: A local-table load whose selector has bits 15:2 all zero stores the selector, clears `ldt_valid`, reports fault kind 0 and makes no memory access.
- R4: A task register load whose selector has bits 15:2 all zero ends with fault kind 2 and error code 0.
- R5: A selector with bit 2 (table indicator) set ends with fault kind 2. The error code is the selector with bits 1:0 cleared, and no memory is accessed.
- R6: If {selector[15:3], 3'b111} is greater than `table_limit`, the load ends with fault kind 2 and the selector-derived code, before any memory access. When the two are equal, the load goes on to read the descriptor.
- R7: The descriptor is read at base+index*8 and then at base+index*8+4. Each request stays asserted with a stable address until `mem_ack`.
- R8: The descriptor's high word must have bit 12 clear and bits 11:8 equal to 2 for a local-table load, or equal to 1 or 9 for a task register load. Any other value ends with fault kind 2 and the selector-derived code.
- R9: If the type check passes but bit 15 of the high word is clear, the load ends with fault kind 3 and the selector-derived code. A descriptor that is wrong in both type and presence gives fault kind 2.
- R10: On success the chosen register takes the selector and {high word, low word}, its valid bit is set, and the fault kind is 0.
- R11: A successful task register load writes the high word with bit 9 set to base+index*8+4 before it finishes. A local-table load never writes.
- R12: After reset no register is valid and `done` is low. `done` is a one-cycle pulse. A faulting load leaves every stored selector, descriptor and valid bit unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a load (sampled while idle) |
| load_tr | input | 1 | 1 = task register, 0 = local descriptor table register |
| selector | input | 16 | Selector to load |
| cpl | input | 2 | Current privilege level |
| prot_mode | input | 1 | 1 = protected mode, 0 = real or virtual-8086 |
| table_base | input | ADDR_W | Global table base address |
| table_limit | input | 16 | Global table limit (last valid byte offset) |
| mem_req | output | 1 | Memory request, held until acknowledged |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | ADDR_W | Byte address of the 32-bit word |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid with mem_ack |
| mem_ack | input | 1 | Completes the current request |
| ldt_sel | output | 16 | Stored local-table selector |
| ldt_desc | output | 64 | Stored local-table descriptor {high, low} |
| ldt_valid | output | 1 | Local-table cache valid |
| tr_sel | output | 16 | Stored task register selector |
| tr_desc | output | 64 | Stored task descriptor {high, low} |
| tr_valid | output | 1 | Task register cache valid |
| done | output | 1 | One-cycle end-of-sequence pulse |
| fault_kind | output | 2 | 0 none, 1 undefined opcode, 2 general protection, 3 not present |
| err_code | output | 16 | Fault error code |

## Verification
Selectors are chosen so that each one fails a different stage of the check chain. A single table entry, reached with different mode, privilege, null, table-indicator and limit settings, shows which precheck fired, because the error code and the number of memory accesses differ. Descriptors that are wrong in type, in presence, or in both separate the type check from the presence check and confirm that the type check runs first. Successful loads of each accepted type check the two read addresses, the busy write-back left in the memory model, and that a later faulting load leaves the stored registers as they were.

// File: rtl/dtr_pkg.sv
package dtr_pkg;
  typedef enum logic [1:0] {
    FLT_NONE = 2'd0,
    FLT_UD   = 2'd1,
    FLT_GP   = 2'd2,
    FLT_NP   = 2'd3
  } fault_e;

  typedef enum logic [2:0] {
    ST_IDLE, ST_RD_LO, ST_RD_HI, ST_EVAL, ST_WR_HI
  } state_e;

  localparam logic [3:0] TY_LDT      = 4'h2;
  localparam logic [3:0] TY_TSS16_AV = 4'h1;
  localparam logic [3:0] TY_TSS32_AV = 4'h9;
  localparam int         BUSY_BIT    = 9;
  localparam int         SYS_BIT     = 12;
  localparam int         PRES_BIT    = 15;

  // error code carried by selector-related faults
  function automatic logic [15:0] sel_err(input logic [15:0] s);
    return {s[15:2], 2'b00};
  endfunction

  // byte offset of the entry inside the table
  function automatic logic [15:0] entry_off(input logic [15:0] s);
    return {s[15:3], 3'b000};
  endfunction

  // last byte offset covered by the entry
  function automatic logic [15:0] entry_end(input logic [15:0] s);
    return {s[15:3], 3'b111};
  endfunction

  function automatic logic is_null(input logic [15:0] s);
    return s[15:2] == 14'd0;
  endfunction
endpackage

// File: rtl/dtr_sel_check.sv
module dtr_sel_check
  import dtr_pkg::*;
(
  input  logic        prot_mode,
  input  logic [1:0]  cpl,
  input  logic        load_tr,
  input  logic [15:0] selector,
  input  logic [15:0] table_limit,
  output fault_e      pre_fault,
  output logic [15:0] pre_code,
  output logic        null_ldt
);
  always_comb begin
    pre_fault = FLT_NONE;
    pre_code  = 16'd0;
    null_ldt  = 1'b0;
    if (!prot_mode) begin
      pre_fault = FLT_UD;
    end else if (cpl != 2'd0) begin
      pre_fault = FLT_GP;
    end else if (is_null(selector)) begin
      if (load_tr) pre_fault = FLT_GP;
      else         null_ldt  = 1'b1;
    end else if (selector[2]) begin
      pre_fault = FLT_GP;
      pre_code  = sel_err(selector);
    end else if (entry_end(selector) > table_limit) begin
      pre_fault = FLT_GP;
      pre_code  = sel_err(selector);
    end
  end
endmodule

// File: rtl/dtr_desc_check.sv
module dtr_desc_check
  import dtr_pkg::*;
(
  input  logic        load_tr,
  input  logic [15:0] selector,
  input  logic [31:0] desc_hi,
  output fault_e      desc_fault,
  output logic [15:0] desc_code
);
  logic [3:0] ty;
  logic       type_ok;

  assign ty = desc_hi[11:8];

  always_comb begin
    if (desc_hi[SYS_BIT])
      type_ok = 1'b0;
    else if (load_tr)
      type_ok = (ty == TY_TSS16_AV) || (ty == TY_TSS32_AV);
    else
      type_ok = (ty == TY_LDT);
  end

  always_comb begin
    desc_fault = FLT_NONE;
    desc_code  = 16'd0;
    if (!type_ok) begin
      desc_fault = FLT_GP;
      desc_code  = sel_err(selector);
    end else if (!desc_hi[PRES_BIT]) begin
      desc_fault = FLT_NP;
      desc_code  = sel_err(selector);
    end
  end
endmodule

// File: rtl/dtr_load_seq.sv
module dtr_load_seq
  import dtr_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              load_tr,
  input  logic [15:0]       selector,
  input  logic [1:0]        cpl,
  input  logic              prot_mode,
  input  logic [ADDR_W-1:0] table_base,
  input  logic [15:0]       table_limit,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [31:0]       mem_wdata,
  input  logic [31:0]       mem_rdata,
  input  logic              mem_ack,
  output logic [15:0]       ldt_sel,
  output logic [63:0]       ldt_desc,
  output logic              ldt_valid,
  output logic [15:0]       tr_sel,
  output logic [63:0]       tr_desc,
  output logic              tr_valid,
  output logic              done,
  output logic [1:0]        fault_kind,
  output logic [15:0]       err_code
);
  localparam logic [ADDR_W-1:0] HI_STEP = ADDR_W'(4);

  state_e            state;
  logic              r_tr;
  logic [15:0]       r_sel;
  logic [ADDR_W-1:0] r_base;
  logic [31:0]       lo_q, hi_q;
  fault_e            fault_q;

  fault_e      pre_fault, desc_fault;
  logic [15:0] pre_code, desc_code;
  logic        null_ldt;

  dtr_sel_check u_sel (
    .prot_mode (prot_mode),
    .cpl       (cpl),
    .load_tr   (load_tr),
    .selector  (selector),
    .table_limit(table_limit),
    .pre_fault (pre_fault),
    .pre_code  (pre_code),
    .null_ldt  (null_ldt)
  );

  dtr_desc_check u_desc (
    .load_tr   (r_tr),
    .selector  (r_sel),
    .desc_hi   (hi_q),
    .desc_fault(desc_fault),
    .desc_code (desc_code)
  );

  // named internal events
  logic accept, pre_fail, eval_fail, finish_ldt, finish_tr;
  assign accept     = (state == ST_IDLE) && start;
  assign pre_fail   = accept && (pre_fault != FLT_NONE);
  assign eval_fail  = (state == ST_EVAL) && (desc_fault != FLT_NONE);
  assign finish_ldt = (state == ST_EVAL) && (desc_fault == FLT_NONE) && !r_tr;
  assign finish_tr  = (state == ST_WR_HI) && mem_ack;

  assign mem_req   = (state == ST_RD_LO) || (state == ST_RD_HI) || (state == ST_WR_HI);
  assign mem_we    = (state == ST_WR_HI);
  assign mem_addr  = r_base + ADDR_W'(entry_off(r_sel)) + ((state == ST_RD_LO) ? '0 : HI_STEP);
  assign mem_wdata = hi_q | (32'd1 << BUSY_BIT);
  assign fault_kind = fault_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      r_tr      <= 1'b0;
      r_sel     <= '0;
      r_base    <= '0;
      lo_q      <= '0;
      hi_q      <= '0;
      ldt_sel   <= '0;
      ldt_desc  <= '0;
      ldt_valid <= 1'b0;
      tr_sel    <= '0;
      tr_desc   <= '0;
      tr_valid  <= 1'b0;
      done      <= 1'b0;
      fault_q   <= FLT_NONE;
      err_code  <= '0;
    end else begin
      done <= 1'b0;
      unique case (state)
        ST_IDLE: if (start) begin
          r_tr   <= load_tr;
          r_sel  <= selector;
          r_base <= table_base;
          if (pre_fail) begin
            done     <= 1'b1;
            fault_q  <= pre_fault;
            err_code <= pre_code;
          end else if (null_ldt) begin
            ldt_sel   <= selector;
            ldt_valid <= 1'b0;
            done      <= 1'b1;
            fault_q   <= FLT_NONE;
            err_code  <= '0;
          end else begin
            state <= ST_RD_LO;
          end
        end
        ST_RD_LO: if (mem_ack) begin
          lo_q  <= mem_rdata;
          state <= ST_RD_HI;
        end
        ST_RD_HI: if (mem_ack) begin
          hi_q  <= mem_rdata;
          state <= ST_EVAL;
        end
        ST_EVAL: begin
          if (eval_fail) begin
            done     <= 1'b1;
            fault_q  <= desc_fault;
            err_code <= desc_code;
            state    <= ST_IDLE;
          end else if (r_tr) begin
            state <= ST_WR_HI;
          end else begin
            ldt_sel   <= r_sel;
            ldt_desc  <= {hi_q, lo_q};
            ldt_valid <= 1'b1;
            done      <= 1'b1;
            fault_q   <= FLT_NONE;
            err_code  <= '0;
            state     <= ST_IDLE;
          end
        end
        ST_WR_HI: if (mem_ack) begin
          tr_sel   <= r_sel;
          tr_desc  <= {hi_q, lo_q};
          tr_valid <= 1'b1;
          done     <= 1'b1;
          fault_q  <= FLT_NONE;
          err_code <= '0;
          state    <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R1: outside protected mode a start ends at once with undefined opcode
  a_r1_mode_ud: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE && start && !prot_mode) |=> (done && fault_kind == 2'd1 && !mem_req));

  // R7: a pending request keeps its address and direction until acknowledged
  a_r7_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

  // R11: only task register loads write, and the written word carries busy
  a_r11_write_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we) |-> (r_tr && mem_wdata[BUSY_BIT]));

  // R12: done is a single-cycle pulse
  a_r12_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R12: a faulting finish leaves stored state unchanged
  a_r12_fault_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    (done && fault_kind != 2'd0) |-> ($stable(ldt_sel) && $stable(ldt_valid) &&
                                      $stable(tr_sel) && $stable(tr_valid) &&
                                      $stable(ldt_desc) && $stable(tr_desc)));

  // R9: a not-present fault only follows a completed descriptor read
  a_r9_np_after_read: assert property (@(posedge clk) disable iff (!rst_n)
    (eval_fail && desc_fault == FLT_NP) |-> !hi_q[PRES_BIT]);
endmodule

// File: tb/dtr_load_seq_test.sv
module dtr_load_seq_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        load_tr = 1'b0;
  logic [15:0] selector = '0;
  logic [1:0]  cpl = '0;
  logic        prot_mode = 1'b1;
  logic [31:0] table_base = 32'h0000_1000;
  logic [15:0] table_limit = 16'h00FF;
  logic        mem_req, mem_we, mem_ack;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic [15:0] ldt_sel, tr_sel, err_code;
  logic [63:0] ldt_desc, tr_desc;
  logic        ldt_valid, tr_valid, done;
  logic [1:0]  fault_kind;

  int tests = 0;
  int fails = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  dtr_load_seq uut (
    .clk(clk), .rst_n(rst_n), .start(start), .load_tr(load_tr),
    .selector(selector), .cpl(cpl), .prot_mode(prot_mode),
    .table_base(table_base), .table_limit(table_limit),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ack(mem_ack),
    .ldt_sel(ldt_sel), .ldt_desc(ldt_desc), .ldt_valid(ldt_valid),
    .tr_sel(tr_sel), .tr_desc(tr_desc), .tr_valid(tr_valid),
    .done(done), .fault_kind(fault_kind), .err_code(err_code)
  );

  // memory model: 64 words at table_base, ack one cycle after request
  logic [31:0] mem [64];
  logic [31:0] acc_addr [8];
  logic        acc_we [8];
  int          acc_n = 0;
  logic [5:0]  widx;
  assign widx      = mem_addr[7:2] - table_base[7:2];
  assign mem_rdata = mem[widx];

  always @(posedge clk) begin
    if (!rst_n) mem_ack <= 1'b0;
    else        mem_ack <= mem_req && !mem_ack;
    if (rst_n && mem_req && mem_ack) begin
      if (mem_we) mem[widx] <= mem_wdata;
      if (acc_n < 8) begin
        acc_addr[acc_n] = mem_addr;
        acc_we[acc_n]   = mem_we;
      end
      acc_n = acc_n + 1;
    end
  end

  function automatic logic [31:0] mk_hi(input bit p, input bit s, input logic [3:0] ty);
    return 32'h0040_0000 | (32'(p) << 15) | (32'(s) << 12) | (32'(ty) << 8);
  endfunction

  task automatic put(input int idx, input logic [31:0] hi, input logic [31:0] lo);
    mem[idx*2]   = lo;
    mem[idx*2+1] = hi;
  endtask

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic run(input bit tr, input logic [15:0] sel, input logic [1:0] c, input bit pm);
    int n = 0;
    @(negedge clk);
    load_tr = tr; selector = sel; cpl = c; prot_mode = pm;
    acc_n = 0;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (!done && n < 40) begin
      @(negedge clk);
      n++;
    end
    chk("R12 done seen", {63'd0, done}, 64'd1);
  endtask

  task automatic after_pulse();
    @(negedge clk);
    chk("R12 done one cycle", {63'd0, done}, 64'd0);
  endtask

  task automatic t_reset();
    chk("R12 reset done", {63'd0, done}, 0);
    chk("R12 reset ldt_valid", {63'd0, ldt_valid}, 0);
    chk("R12 reset tr_valid", {63'd0, tr_valid}, 0);
    chk("R12 reset req", {63'd0, mem_req}, 0);
  endtask

  task automatic t_mode();
    run(0, 16'h0008, 2'd3, 0);
    chk("R1 kind", fault_kind, 1);
    chk("R1 code", err_code, 0);
    chk("R1 no access", acc_n, 0);
    after_pulse();
  endtask

  task automatic t_cpl();
    run(0, 16'h0008, 2'd1, 1);
    chk("R2 kind", fault_kind, 2);
    chk("R2 code", err_code, 0);
    chk("R2 no access", acc_n, 0);
  endtask

  task automatic t_ldt_ok();
    run(0, 16'h000B, 2'd0, 1);
    chk("R10 kind", fault_kind, 0);
    chk("R10 ldt_sel", ldt_sel, 16'h000B);
    chk("R10 ldt_desc", ldt_desc, {mk_hi(1, 0, 4'h2), 32'hABCD_0123});
    chk("R10 ldt_valid", ldt_valid, 1);
    chk("R7 access count", acc_n, 2);
    chk("R7 first addr", acc_addr[0], 32'h0000_1008);
    chk("R7 second addr", acc_addr[1], 32'h0000_100C);
    chk("R11 ldt no write", {62'd0, acc_we[0], acc_we[1]}, 0);
    after_pulse();
  endtask

  task automatic t_keep();
    run(0, 16'h0010, 2'd0, 1); // data segment: wrong type
    chk("R8 kind", fault_kind, 2);
    chk("R8 code", err_code, 16'h0010);
    chk("R12 ldt_sel kept", ldt_sel, 16'h000B);
    chk("R12 ldt_valid kept", ldt_valid, 1);
    chk("R12 ldt_desc kept", ldt_desc, {mk_hi(1, 0, 4'h2), 32'hABCD_0123});
  endtask

  task automatic t_null();
    run(0, 16'h0003, 2'd0, 1);
    chk("R3 kind", fault_kind, 0);
    chk("R3 sel stored", ldt_sel, 16'h0003);
    chk("R3 valid cleared", ldt_valid, 0);
    chk("R3 no access", acc_n, 0);
    run(1, 16'h0002, 2'd0, 1);
    chk("R4 kind", fault_kind, 2);
    chk("R4 code", err_code, 0);
    chk("R4 tr_valid", tr_valid, 0);
  endtask

  task automatic t_ti();
    run(0, 16'h000F, 2'd0, 1);
    chk("R5 kind", fault_kind, 2);
    chk("R5 code", err_code, 16'h000C);
    chk("R5 no access", acc_n, 0);
  endtask

  task automatic t_limit();
    table_limit = 16'h0017;
    run(0, 16'h0018, 2'd0, 1);
    chk("R6 over kind", fault_kind, 2);
    chk("R6 over code", err_code, 16'h0018);
    chk("R6 over no access", acc_n, 0);
    run(0, 16'h0010, 2'd0, 1);
    chk("R6 equal reads", acc_n, 2);
    chk("R6 equal code", err_code, 16'h0010);
    table_limit = 16'h00FF;
  endtask

  task automatic t_types();
    run(1, 16'h0008, 2'd0, 1);
    chk("R8 tr on ldt kind", fault_kind, 2);
    chk("R8 tr on ldt code", err_code, 16'h0008);
    run(1, 16'h0030, 2'd0, 1);
    chk("R8 busy tss kind", fault_kind, 2);
    chk("R8 busy tss code", err_code, 16'h0030);
    chk("R8 tr_valid", tr_valid, 0);
  endtask

  task automatic t_np();
    run(0, 16'h0018, 2'd0, 1);
    chk("R9 np kind", fault_kind, 3);
    chk("R9 np code", err_code, 16'h0018);
    run(0, 16'h0038, 2'd0, 1);
    chk("R9 order kind", fault_kind, 2);
    chk("R9 order code", err_code, 16'h0038);
  endtask

  task automatic t_tr_ok();
    run(1, 16'h0021, 2'd0, 1);
    chk("R10 tr kind", fault_kind, 0);
    chk("R10 tr_sel", tr_sel, 16'h0021);
    chk("R10 tr_desc", tr_desc, {mk_hi(1, 0, 4'h1), 32'h1111_2222});
    chk("R10 tr_valid", tr_valid, 1);
    chk("R11 access count", acc_n, 3);
    chk("R11 write addr", acc_addr[2], 32'h0000_1024);
    chk("R11 write flag", acc_we[2], 1);
    chk("R11 busy in memory", mem[9], mk_hi(1, 0, 4'h3));
    run(1, 16'h0028, 2'd0, 1);
    chk("R10 tss32 tr_sel", tr_sel, 16'h0028);
    chk("R11 tss32 busy", mem[11], mk_hi(1, 0, 4'hB));
    run(1, 16'h0021, 2'd0, 1);
    chk("R8 reload busy kind", fault_kind, 2);
    chk("R12 tr_sel kept", tr_sel, 16'h0028);
  endtask

  initial begin
    for (int i = 0; i < 64; i++) mem[i] = 32'h0;
    put(1, mk_hi(1, 0, 4'h2), 32'hABCD_0123);
    put(2, mk_hi(1, 1, 4'h2), 32'h5555_0000);
    put(3, mk_hi(0, 0, 4'h2), 32'h6666_0000);
    put(4, mk_hi(1, 0, 4'h1), 32'h1111_2222);
    put(5, mk_hi(1, 0, 4'h9), 32'h3333_4444);
    put(6, mk_hi(1, 0, 4'hB), 32'h7777_0000);
    put(7, mk_hi(0, 0, 4'h5), 32'h8888_0000);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_mode();
    t_cpl();
    t_ldt_ok();
    t_keep();
    t_null();
    t_ti();
    t_limit();
    t_types();
    t_np();
    t_tr_ok();
    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #200000;
    if (!finished) begin
      tests++;
      fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule